// File: doc/BRIEF.md
# Four-Stage Watchdog with Keyed Stop

This block is a watchdog peripheral with its own tick timer. The tick timer takes a 1 MHz clock-enable pulse and gives one watchdog tick after a programmed number of those pulses. It can run periodically or fire once. When the watchdog is running, it counts its period down by one on each tick. Each time the count runs out, the count reloads and a two-bit expiry counter moves up. The chip-reset request is raised only on the fourth expiry in a row. An interrupt can be raised on the first expiry, which gives software time to act before the reset.

Software reaches the block through a small write bus with a combinational read port. The command word starts the counter, and the same command sent again while running is the keep-alive. The command word can also stop the counter. A stop is only accepted when the key word was written to the key register just before it. The remaining time in ticks can be worked out from the status word: (3 − expiries) × period + count.

Top module: `msw_top`

## Requirements
- R1: After reset, `wdt_irq` and `wdt_sys_rst` are low, and reads of the status (0x04), config (0x00) and timer (0x10) addresses return zero.
- R2: The timer word at 0x10 holds the tick divisor in bits 23:0, enable in bit 31 and auto-reload in bit 30. When enabled with divisor P, one watchdog tick occurs per P enable pulses. With auto-reload clear, only one tick occurs. Writing zero stops ticks, which freezes the countdown.
- R3: A start command (write to 0x08 with bit 0 set) loads the count from config bits 11:4 and clears the expiry count. Status reports the count in bits 11:4 and the expiries in bits 13:12.
- R4: While running, each tick lowers the count by one. A tick at count 1 reloads the period and raises the expiry count, which stops at 3.
- R5: With config bit 15 set, `wdt_sys_rst` rises on the fourth expiry. It stays high through later starts and config writes until an accepted stop or block reset. With bit 15 clear, it never rises.
- R6: With config bit 12 set, `wdt_irq` rises on the first expiry and stays high until the next start. With bit 12 clear, it never rises.
- R7: A start while running reloads the count, clears the expiry count and drops `wdt_irq`.
- R8: A stop command (bit 1 at 0x08) is accepted only right after 0xC45A was written to 0x0C. An accepted stop freezes count and expiries and drops `wdt_sys_rst`. An unkeyed stop is ignored and counting goes on.
- R9: Any write to 0x08 uses up the key. A key write with any other value does not arm the stop.
- R10: The config and timer words read back the written fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick_en | input | 1 | 1 MHz clock-enable pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_irq | output | 1 | First-expiry interrupt |
| wdt_sys_rst | output | 1 | Chip-reset request |

## Verification
Watchdog periods 1 to 6 are each swept tick by tick, past the fourth expiry. Count, expiries, interrupt and reset are checked against arithmetic from the tick number, which tells the reload point apart from an off-by-one and shows that the expiry count stops at 3. Further patterns cover:
- the tick divisor at 3;
- the single-shot timer;
- a zero timer word, which tells timer gating apart from countdown logic;
- the enable bits cleared;
- a keep-alive in mid-count;
- stops with no key, a wrong key, and a key used up by a start, each set against a proper keyed stop.

// File: rtl/msw_pkg.sv
// Package: register addresses and bit positions shared by the watchdog
// modules, plus the decoded-write struct passed from the register file.
package msw_pkg;
    localparam logic [4:0] ADDR_CFG = 5'h00;
    localparam logic [4:0] ADDR_STS = 5'h04;
    localparam logic [4:0] ADDR_CMD = 5'h08;
    localparam logic [4:0] ADDR_KEY = 5'h0C;
    localparam logic [4:0] ADDR_TMR = 5'h10;

    localparam int CFG_PER_LSB  = 4;
    localparam int CFG_IRQ_BIT  = 12;
    localparam int CFG_RST_BIT  = 15;
    localparam int STS_EXP_LSB  = 12;
    localparam int CMD_GO_BIT   = 0;
    localparam int CMD_HALT_BIT = 1;
    localparam int TMR_EN_BIT   = 31;
    localparam int TMR_AUTO_BIT = 30;

    localparam logic [15:0] KEY_WORD = 16'hC45A;

    typedef struct packed {
        logic wr_cfg;
        logic wr_cmd;
        logic wr_key;
        logic wr_tmr;
    } bus_dec_t;
endpackage

// File: rtl/msw_regs.sv
// Register file: decodes writes, holds the config and timer words and the
// stop key. Assumes one write per cycle and the addresses in msw_pkg.
module msw_regs
    import msw_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [4:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output bus_dec_t         dec,
    output logic [15:0]      cfg_q,
    output logic [TMR_W-1:0] tmr_per,
    output logic             tmr_en,
    output logic             tmr_auto,
    output logic             key_armed
);
    // Decode the write strobe into one flag per register.
    always_comb begin
        dec.wr_cfg = bus_wr && (bus_addr == ADDR_CFG);
        dec.wr_cmd = bus_wr && (bus_addr == ADDR_CMD);
        dec.wr_key = bus_wr && (bus_addr == ADDR_KEY);
        dec.wr_tmr = bus_wr && (bus_addr == ADDR_TMR);
    end

    // Hold the config and timer words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            tmr_per  <= '0;
            tmr_en   <= 1'b0;
            tmr_auto <= 1'b0;
        end else begin
            if (dec.wr_cfg) cfg_q <= bus_wdata[15:0];
            if (dec.wr_tmr) begin
                tmr_per  <= bus_wdata[TMR_W-1:0];
                tmr_en   <= bus_wdata[TMR_EN_BIT];
                tmr_auto <= bus_wdata[TMR_AUTO_BIT];
            end
        end
    end

    // Arm the stop key on the exact word; any command write uses it up.
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_armed <= 1'b0;
        else if (dec.wr_cmd)
            key_armed <= 1'b0;
        else if (dec.wr_key)
            key_armed <= (bus_wdata[15:0] == KEY_WORD);
    end
endmodule

// File: rtl/msw_tick.sv
// Tick timer: divides the 1 MHz enable by a programmed divisor and gives
// one-cycle ticks. Single-shot mode fires once per write of the timer word.
// Assumes a divisor of zero means no ticks.
module msw_tick #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick_en,
    input  logic             reload,
    input  logic             en,
    input  logic             auto,
    input  logic [TMR_W-1:0] per,
    output logic             tick
);
    logic [TMR_W-1:0] acc;
    logic             spent;
    logic             active;

    // Tick when the pulse count reaches the divisor.
    always_comb begin
        active = en && !spent && !reload && (per != '0);
        tick   = active && us_tick_en && (acc >= per - 1'b1);
    end

    // Count enable pulses; restart on a write to the timer word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            spent <= 1'b0;
        end else if (reload) begin
            acc   <= '0;
            spent <= 1'b0;
        end else if (active && us_tick_en) begin
            if (tick) begin
                acc   <= '0;
                spent <= !auto;
            end else begin
                acc <= acc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/msw_count.sv
// Countdown and expiry tracking: reloads on each expiry, raises the
// interrupt on the first one and the reset request on the last stage.
// Assumes go and halt are never both high (the top qualifies them).
module msw_count #(
    parameter int PER_W  = 8,
    parameter int STAGES = 4,
    localparam int EXP_W = $clog2(STAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic             halt,
    input  logic [PER_W-1:0] period,
    input  logic             irq_en,
    input  logic             rst_en,
    output logic [PER_W-1:0] count,
    output logic [EXP_W-1:0] expiries,
    output logic             run,
    output logic             irq,
    output logic             sys_rst
);
    localparam logic [EXP_W-1:0] LAST = EXP_W'(STAGES - 1);

    logic expire;

    // An expiry happens on a tick while the count stands at one (or zero).
    always_comb expire = run && tick && (count <= PER_W'(1));

    // Sequence commands, countdown, expiries and the two outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            expiries <= '0;
            run      <= 1'b0;
            irq      <= 1'b0;
            sys_rst  <= 1'b0;
        end else if (halt) begin
            run     <= 1'b0;
            sys_rst <= 1'b0;
        end else if (go) begin
            run      <= 1'b1;
            count    <= period;
            expiries <= '0;
            irq      <= 1'b0;
        end else if (expire) begin
            count <= period;
            if (expiries == LAST)
                sys_rst <= sys_rst | rst_en;
            else
                expiries <= expiries + 1'b1;
            if (expiries == '0 && irq_en)
                irq <= 1'b1;
        end else if (run && tick) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/msw_top.sv
// Top level: wires the register file, tick timer and countdown together,
// qualifies start/stop commands and builds the read word.
// Assumes PER_W <= 8 and a 2-bit expiry field (STAGES = 4) for the layout.
module msw_top
    import msw_pkg::*;
#(
    parameter int TMR_W  = 24,
    parameter int PER_W  = 8,
    parameter int STAGES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        us_tick_en,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_irq,
    output logic        wdt_sys_rst
);
    localparam int EXP_W = $clog2(STAGES);

    bus_dec_t         dec;
    logic [15:0]      cfg_q;
    logic [TMR_W-1:0] tmr_per;
    logic             tmr_en;
    logic             tmr_auto;
    logic             key_armed;
    logic             tick;
    logic             go;
    logic             halt;
    logic [PER_W-1:0] wd_count;
    logic [EXP_W-1:0] wd_exp;
    logic             wd_run;

    msw_regs #(.TMR_W(TMR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .dec(dec), .cfg_q(cfg_q), .tmr_per(tmr_per),
        .tmr_en(tmr_en), .tmr_auto(tmr_auto), .key_armed(key_armed)
    );

    msw_tick #(.TMR_W(TMR_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .us_tick_en(us_tick_en),
        .reload(dec.wr_tmr), .en(tmr_en), .auto(tmr_auto),
        .per(tmr_per), .tick(tick)
    );

    // A keyed stop takes priority over a start in the same word.
    always_comb begin
        halt = dec.wr_cmd && bus_wdata[CMD_HALT_BIT] && key_armed;
        go   = dec.wr_cmd && bus_wdata[CMD_GO_BIT] && !halt;
    end

    msw_count #(.PER_W(PER_W), .STAGES(STAGES)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .halt(halt),
        .period(cfg_q[CFG_PER_LSB +: PER_W]),
        .irq_en(cfg_q[CFG_IRQ_BIT]), .rst_en(cfg_q[CFG_RST_BIT]),
        .count(wd_count), .expiries(wd_exp), .run(wd_run),
        .irq(wdt_irq), .sys_rst(wdt_sys_rst)
    );

    // Build the read word for the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CFG: bus_rdata[15:0] = cfg_q;
            ADDR_STS: begin
                bus_rdata[CFG_PER_LSB +: PER_W] = wd_count;
                bus_rdata[STS_EXP_LSB +: EXP_W] = wd_exp;
            end
            ADDR_TMR: begin
                bus_rdata[TMR_W-1:0]   = tmr_per;
                bus_rdata[TMR_EN_BIT]   = tmr_en;
                bus_rdata[TMR_AUTO_BIT] = tmr_auto;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msw_checker.sv
// Checker: timing properties of the watchdog, bound to msw_top.
module msw_checker
    import msw_pkg::*;
#(
    parameter int PER_W = 8,
    parameter int EXP_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [4:0]       bus_addr,
    input logic [1:0]       cmd_bits,
    input logic             tick,
    input logic             tmr_en,
    input logic             wd_run,
    input logic [PER_W-1:0] wd_count,
    input logic [EXP_W-1:0] wd_exp,
    input logic             wdt_irq,
    input logic             wdt_sys_rst
);
    logic cmd_wr;
    always_comb cmd_wr = bus_wr && (bus_addr == ADDR_CMD);

    assert_no_tick_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |-> !tick);

    assert_count_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wd_run && wd_count > PER_W'(1) && !cmd_wr)
        |=> wd_count == PER_W'($past(wd_count) - 1'b1));

    assert_reset_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_sys_rst && !(cmd_wr && cmd_bits[1])) |=> wdt_sys_rst);

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_irq && !(cmd_wr && cmd_bits[0])) |=> wdt_irq);

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_bits[0] && !cmd_bits[1]) |=> (wd_run && wd_exp == '0 && !wdt_irq));

    assert_frozen_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_run && !cmd_wr) |=> ($stable(wd_count) && $stable(wd_exp)));
endmodule

bind msw_top msw_checker #(.PER_W(PER_W), .EXP_W(EXP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .cmd_bits(bus_wdata[1:0]), .tick(tick), .tmr_en(tmr_en),
    .wd_run(wd_run), .wd_count(wd_count), .wd_exp(wd_exp),
    .wdt_irq(wdt_irq), .wdt_sys_rst(wdt_sys_rst)
);

// File: tb/tb_msw_top.sv
module tb_msw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq;
    logic        wdt_sys_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] rv;

    msw_top dut (
        .clk(clk), .rst_n(rst_n), .us_tick_en(us_tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_irq(wdt_irq), .wdt_sys_rst(wdt_sys_rst)
    );

    always #4 clk = ~clk;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            report();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); us_tick_en = 1'b1;
            @(negedge clk); us_tick_en = 1'b0;
        end
    endtask

    function automatic logic [31:0] sts(input int cnt, input int e);
        return (32'(e) << 12) | (32'(cnt) << 4);
    endfunction

    function automatic logic [31:0] cfgw(input int p, input bit ie, input bit re);
        return (32'(p) << 4) | (32'(ie) << 12) | (32'(re) << 15);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 irq", 32'(wdt_irq), 0);
        chk("R1 sysrst", 32'(wdt_sys_rst), 0);
        rd(5'h04, rv); chk("R1 status", rv, 0);
        rd(5'h00, rv); chk("R1 config", rv, 0);
        rd(5'h10, rv); chk("R1 timer", rv, 0);

        // R10: readback
        wr(5'h00, 32'h0000_9A35); rd(5'h00, rv); chk("R10 config", rv, 32'h0000_9A35);
        wr(5'h10, 32'hC000_0001); rd(5'h10, rv); chk("R10 timer", rv, 32'hC000_0001);

        // Sweep of watchdog periods, one tick per pulse: R3 R4 R5 R6 R8
        for (int p = 1; p <= 6; p++) begin
            wr(5'h00, cfgw(p, 1, 1));
            wr(5'h08, 1);
            rd(5'h04, rv); chk("R3 start load", rv, sts(p, 0));
            for (int n = 1; n <= 4 * p + 2; n++) begin
                int e;
                pulse(1);
                e = n / p; if (e > 3) e = 3;
                rd(5'h04, rv); chk("R4 count/exp", rv, sts(p - (n % p), e));
                chk("R6 irq first expiry", 32'(wdt_irq), 32'(n >= p));
                chk("R5 reset on fourth", 32'(wdt_sys_rst), 32'(n >= 4 * p));
            end
            wr(5'h0C, 32'h0000_C45A);
            wr(5'h08, 2);
            chk("R8 keyed stop drops reset", 32'(wdt_sys_rst), 0);
            rd(5'h04, rv);
            pulse(2);
            begin
                logic [31:0] rv2;
                rd(5'h04, rv2); chk("R8 frozen after stop", rv2, rv);
            end
        end

        // R5 R6: enables cleared
        wr(5'h00, cfgw(3, 0, 0)); wr(5'h08, 1); pulse(13);
        chk("R6 irq off when disabled", 32'(wdt_irq), 0);
        chk("R5 reset off when disabled", 32'(wdt_sys_rst), 0);
        rd(5'h04, rv); chk("R4 exp saturates", rv, sts(2, 3));

        // R7: keep-alive
        wr(5'h00, cfgw(3, 1, 1)); wr(5'h08, 1); pulse(4);
        rd(5'h04, rv); chk("R7 before keepalive", rv, sts(2, 1));
        chk("R7 irq before keepalive", 32'(wdt_irq), 1);
        wr(5'h08, 1);
        rd(5'h04, rv); chk("R7 reload", rv, sts(3, 0));
        chk("R7 irq cleared", 32'(wdt_irq), 0);

        // R8: stop without key ignored
        wr(5'h08, 2); pulse(1);
        rd(5'h04, rv); chk("R8 unkeyed stop ignored", rv, sts(2, 0));
        // R9: wrong key does not arm
        wr(5'h0C, 32'h0000_1234); wr(5'h08, 2); pulse(1);
        rd(5'h04, rv); chk("R9 wrong key", rv, sts(1, 0));
        // R9: key used up by a start
        wr(5'h0C, 32'h0000_C45A); wr(5'h08, 1); wr(5'h08, 2); pulse(1);
        rd(5'h04, rv); chk("R9 key consumed", rv, sts(2, 0));

        // R2: divisor 3
        wr(5'h10, 32'hC000_0003); wr(5'h08, 1); pulse(2);
        rd(5'h04, rv); chk("R2 no tick before divisor", rv, sts(3, 0));
        pulse(1);
        rd(5'h04, rv); chk("R2 tick at divisor", rv, sts(2, 0));
        pulse(3);
        rd(5'h04, rv); chk("R2 second tick", rv, sts(1, 0));
        // R2: zero timer word freezes
        wr(5'h10, 0); pulse(5);
        rd(5'h04, rv); chk("R2 frozen when timer off", rv, sts(1, 0));
        // R2: single shot
        wr(5'h10, 32'h8000_0002); wr(5'h08, 1); pulse(2);
        rd(5'h04, rv); chk("R2 single shot fires", rv, sts(2, 0));
        pulse(4);
        rd(5'h04, rv); chk("R2 single shot once", rv, sts(2, 0));

        // R5: reset request holds through start and config writes
        wr(5'h10, 32'hC000_0001); wr(5'h00, cfgw(1, 0, 1)); wr(5'h08, 1); pulse(4);
        chk("R5 reset raised", 32'(wdt_sys_rst), 1);
        wr(5'h00, cfgw(1, 0, 0)); wr(5'h08, 1); pulse(1);
        chk("R5 reset held", 32'(wdt_sys_rst), 1);
        wr(5'h08, 2);
        chk("R8 unkeyed stop keeps reset", 32'(wdt_sys_rst), 1);
        wr(5'h0C, 32'h0000_C45A); wr(5'h08, 2);
        chk("R8 keyed stop clears reset", 32'(wdt_sys_rst), 0);

        report();
    end
endmodule